// File: doc/BRIEF.md
# Instruction Length and Format Decoder

This block looks at the leading op-code byte of a variable-length instruction stream. It works out the format group and the length of the instruction from the two most significant op-code bits. There are four groups:
- register-to-register
- register with indexed storage
- register/storage/immediate-to-storage
- storage-to-storage

The block reports the group as a 2-bit code and the length in bytes. Both results are registered and appear one cycle after the op-code valid strobe.

The block also holds the sequential instruction address. When the instruction at the current address has been accepted (the advance strobe), the address moves forward by the decoded byte count, so the next instruction is fetched from the new value. A load port can overwrite the address with an external value, for example after a redirect. The load wins over an advance in the same cycle.

Top module: `insn_len_decoder`

## Requirements
- R1: An op-code whose two most significant bits are 00 gives format code 0 (register-to-register) and a length of 2 bytes.
- R2: Top bits 01 give format code 1 (register with indexed storage) and a length of 4 bytes.
- R3: Top bits 10 give format code 2 (register/storage/immediate) and a length of 4 bytes.
- R4: Top bits 11 give format code 3 (storage-to-storage) and a length of 6 bytes.
- R5: The six low op-code bits have no effect on the format code or the length.
- R6: `dec_vld` is high exactly in the cycle after a cycle with `op_vld` high. `fmt` and `len_bytes` keep their values while `op_vld` is low.
- R7: When `adv` is high and `ld_en` is low, `iaddr` becomes `iaddr + len_bytes` on the next cycle.
- R8: When `ld_en` is high, `iaddr` takes `ld_addr` on the next cycle, whatever the value of `adv`.
- R9: The address is 24 bits wide and wraps modulo 2^24 when it advances past the top.
- R10: While reset is active, and after it ends, `iaddr`, `fmt`, `len_bytes` and `dec_vld` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_vld | input | 1 | Op-code byte valid |
| op_byte | input | 8 | Leading op-code byte; bit 7 is the most significant |
| ld_en | input | 1 | Load the instruction address |
| ld_addr | input | 24 | Value to load |
| adv | input | 1 | Current instruction accepted; step the address |
| fmt | output | 2 | Registered format code |
| len_bytes | output | 3 | Registered instruction length in bytes |
| dec_vld | output | 1 | Decode result valid this cycle |
| iaddr | output | 24 | Current instruction address |

## Verification
The bench walks all four top-bit classes, using several different low-bit patterns for each. A decoder that looked at the wrong bit pair, or let the low bits leak in, would report the wrong format or length. It also asserts `ld_en` and `adv` together: a design that gave the advance priority would add the length instead of loading the address. The bench loads an address just below 2^24 and then advances by 6 bytes. A counter with a wrong width or a saturating counter would miss the expected small wrapped value. Finally, an idle stretch with `op_vld` low catches a decoder that fails to hold its last result or raises its valid flag when it should not.

// File: rtl/ilfd_pkg.sv
package ilfd_pkg;
   typedef enum logic [1:0] {
      FMT_REGREG = 2'd0,
      FMT_REGIDX = 2'd1,
      FMT_REGSTO = 2'd2,
      FMT_STOSTO = 2'd3
   } fmt_e;

   // number of halfwords for each format class
   function automatic int unsigned class_halfwords(input int unsigned cls);
      case (cls)
         0:       return 1;
         3:       return 3;
         default: return 2;
      endcase
   endfunction
endpackage

// File: rtl/ilfd_classify.sv
module ilfd_classify #(
   parameter int unsigned OP_W     = 8,
   parameter int unsigned HW_BYTES = 2,
   parameter int unsigned LEN_W    = 3
) (
   input  logic [OP_W-1:0]  op_byte,
   output logic [1:0]       cls,
   output logic [LEN_W-1:0] len
);
   logic [LEN_W-1:0] lut [4];

   generate
      for (genvar k = 0; k < 4; k++) begin : g_lut
         localparam int unsigned BYTES = ilfd_pkg::class_halfwords(k) * HW_BYTES;
         assign lut[k] = LEN_W'(BYTES);
      end
   endgenerate

   assign cls = op_byte[OP_W-1 -: 2];
   assign len = lut[cls];
endmodule

// File: rtl/ilfd_hold.sv
module ilfd_hold #(
   parameter int unsigned LEN_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [1:0]       cls_in,
   input  logic [LEN_W-1:0] len_in,
   output logic [1:0]       cls_q,
   output logic [LEN_W-1:0] len_q,
   output logic             vld_q
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cls_q <= '0;
         len_q <= '0;
         vld_q <= 1'b0;
      end else begin
         vld_q <= load;
         if (load) begin
            cls_q <= cls_in;
            len_q <= len_in;
         end
      end
   end
endmodule

// File: rtl/ilfd_addr.sv
module ilfd_addr #(
   parameter int unsigned ADDR_W = 24,
   parameter int unsigned LEN_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_en,
   input  logic [ADDR_W-1:0] ld_addr,
   input  logic              adv,
   input  logic [LEN_W-1:0]  step,
   output logic [ADDR_W-1:0] addr_q
);
   localparam int unsigned PAD_W = ADDR_W - LEN_W;

   logic [ADDR_W-1:0] step_ext;
   assign step_ext = {{PAD_W{1'b0}}, step};

   always_ff @(posedge clk) begin
      if (!rst_n)      addr_q <= '0;
      else if (ld_en)  addr_q <= ld_addr;
      else if (adv)    addr_q <= addr_q + step_ext;
   end
endmodule

// File: rtl/insn_len_decoder.sv
module insn_len_decoder #(
   parameter int unsigned OP_W     = 8,
   parameter int unsigned ADDR_W   = 24,
   parameter int unsigned HW_BYTES = 2,
   parameter int unsigned LEN_W    = $clog2(3 * HW_BYTES + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_vld,
   input  logic [OP_W-1:0]   op_byte,
   input  logic              ld_en,
   input  logic [ADDR_W-1:0] ld_addr,
   input  logic              adv,
   output logic [1:0]        fmt,
   output logic [LEN_W-1:0]  len_bytes,
   output logic              dec_vld,
   output logic [ADDR_W-1:0] iaddr
);
   generate
      if (OP_W < 2) begin : g_bad_op
         $error("OP_W must be at least 2");
      end
      if (HW_BYTES < 1) begin : g_bad_hw
         $error("HW_BYTES must be at least 1");
      end
      if (ADDR_W <= LEN_W) begin : g_bad_addr
         $error("ADDR_W must exceed LEN_W");
      end
      if ((1 << LEN_W) <= 3 * HW_BYTES) begin : g_bad_len
         $error("LEN_W too narrow for longest instruction");
      end
   endgenerate

   logic [1:0]       cls_d;
   logic [LEN_W-1:0] len_d;

   ilfd_classify #(.OP_W(OP_W), .HW_BYTES(HW_BYTES), .LEN_W(LEN_W)) u_cls (
      .op_byte (op_byte),
      .cls     (cls_d),
      .len     (len_d)
   );

   ilfd_hold #(.LEN_W(LEN_W)) u_hold (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (op_vld),
      .cls_in (cls_d),
      .len_in (len_d),
      .cls_q  (fmt),
      .len_q  (len_bytes),
      .vld_q  (dec_vld)
   );

   ilfd_addr #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_addr (
      .clk     (clk),
      .rst_n   (rst_n),
      .ld_en   (ld_en),
      .ld_addr (ld_addr),
      .adv     (adv),
      .step    (len_bytes),
      .addr_q  (iaddr)
   );
endmodule

// File: rtl/insn_len_decoder_chk.sv
module insn_len_decoder_chk #(
   parameter int unsigned OP_W     = 8,
   parameter int unsigned ADDR_W   = 24,
   parameter int unsigned HW_BYTES = 2,
   parameter int unsigned LEN_W    = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              op_vld,
   input logic [OP_W-1:0]   op_byte,
   input logic              ld_en,
   input logic [ADDR_W-1:0] ld_addr,
   input logic              adv,
   input logic [1:0]        fmt,
   input logic [LEN_W-1:0]  len_bytes,
   input logic              dec_vld,
   input logic [ADDR_W-1:0] iaddr
);
   // R1 R2 R3 R4
   fmt_follows_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
      op_vld |=> fmt == $past(op_byte[OP_W-1 -: 2]));

   // R1 R2 R3 R4
   len_matches_fmt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dec_vld |-> len_bytes == LEN_W'((fmt == 2'd0 ? 1 : fmt == 2'd3 ? 3 : 2) * HW_BYTES));

   // R6
   vld_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
      op_vld |=> dec_vld);

   // R6
   hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !op_vld |=> !dec_vld && $stable(fmt) && $stable(len_bytes));

   // R7 R9
   advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && !ld_en) |=> iaddr == ADDR_W'($past(iaddr) + ADDR_W'($past(len_bytes))));

   // R8
   load_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ld_en |=> iaddr == $past(ld_addr));
endmodule

bind insn_len_decoder insn_len_decoder_chk #(
   .OP_W(OP_W), .ADDR_W(ADDR_W), .HW_BYTES(HW_BYTES), .LEN_W(LEN_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .op_vld(op_vld), .op_byte(op_byte),
   .ld_en(ld_en), .ld_addr(ld_addr), .adv(adv), .fmt(fmt),
   .len_bytes(len_bytes), .dec_vld(dec_vld), .iaddr(iaddr)
);

// File: tb/insn_len_decoder_tb.sv
module insn_len_decoder_tb;
   localparam int CLK_PERIOD = 10;
   localparam int NVEC = 8;
   // {op_byte, expected fmt, expected length}
   localparam logic [12:0] VEC [NVEC] = '{
      {8'h00, 2'd0, 3'd2}, {8'h3F, 2'd0, 3'd2},
      {8'h41, 2'd1, 3'd4}, {8'h7A, 2'd1, 3'd4},
      {8'h80, 2'd2, 3'd4}, {8'hB5, 2'd2, 3'd4},
      {8'hC0, 2'd3, 3'd6}, {8'hFF, 2'd3, 3'd6}
   };

   logic        clk = 0;
   logic        rst_n = 0;
   logic        op_vld = 0;
   logic [7:0]  op_byte = 0;
   logic        ld_en = 0;
   logic [23:0] ld_addr = 0;
   logic        adv = 0;
   logic [1:0]  fmt;
   logic [2:0]  len_bytes;
   logic        dec_vld;
   logic [23:0] iaddr;

   int total = 0;
   int bad = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   insn_len_decoder u_dut (
      .clk(clk), .rst_n(rst_n), .op_vld(op_vld), .op_byte(op_byte),
      .ld_en(ld_en), .ld_addr(ld_addr), .adv(adv), .fmt(fmt),
      .len_bytes(len_bytes), .dec_vld(dec_vld), .iaddr(iaddr)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   string tag;
   logic [23:0] exp_addr;

   initial begin
      repeat (3) step();
      chk("R10 iaddr", 32'(iaddr), 0);
      chk("R10 dec_vld", 32'(dec_vld), 0);
      chk("R10 fmt", 32'(fmt), 0);
      chk("R10 len", 32'(len_bytes), 0);
      rst_n = 1;
      step();
      chk("R10 after reset iaddr", 32'(iaddr), 0);
      exp_addr = 0;

      for (int i = 0; i < NVEC; i++) begin
         logic [7:0] op;
         logic [1:0] ef;
         logic [2:0] el;
         {op, ef, el} = VEC[i];
         case (ef)
            2'd0: tag = "R1";
            2'd1: tag = "R2";
            2'd2: tag = "R3";
            default: tag = "R4";
         endcase
         op_vld = 1; op_byte = op;
         step();
         op_vld = 0; op_byte = 8'h00;
         chk({tag, " R5 fmt"}, 32'(fmt), 32'(ef));
         chk({tag, " R5 len"}, 32'(len_bytes), 32'(el));
         chk("R6 vld", 32'(dec_vld), 1);
         adv = 1;
         step();
         adv = 0;
         exp_addr = exp_addr + 24'(el);
         chk("R7 advance", 32'(iaddr), 32'(exp_addr));
         chk("R6 vld drop", 32'(dec_vld), 0);
      end

      // R6 hold while idle: last op was 11xxxxxx
      op_byte = 8'h00;
      repeat (3) step();
      chk("R6 hold fmt", 32'(fmt), 3);
      chk("R6 hold len", 32'(len_bytes), 6);

      // R8 load wins over advance
      ld_en = 1; ld_addr = 24'h123456; adv = 1;
      step();
      ld_en = 0; adv = 0;
      chk("R8 load priority", 32'(iaddr), 32'h123456);

      // R9 wrap: load near top, advance by 6
      ld_en = 1; ld_addr = 24'hFFFFFE;
      step();
      ld_en = 0;
      adv = 1;
      step();
      adv = 0;
      chk("R9 wrap", 32'(iaddr), 32'h000004);

      // R7 advance with a short instruction after a format change
      op_vld = 1; op_byte = 8'h1C;
      step();
      op_vld = 0;
      adv = 1;
      step();
      adv = 0;
      chk("R1 R7 step by 2", 32'(iaddr), 32'h000006);

      // R10 mid-run reset
      rst_n = 0;
      step();
      chk("R10 reset iaddr", 32'(iaddr), 0);
      chk("R10 reset vld", 32'(dec_vld), 0);
      rst_n = 1;

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule